// File: doc/BRIEF.md
# Four-Plane NAND Page Striping Scheduler

This block takes a byte stream from a capture source and spreads it over four NAND planes, two on each of two dies that share a single chip enable. Bytes are dealt to the planes in a fixed rotation, so each plane's page fills at a quarter of the input rate. Every accepted byte is presented once on a registered write port. The port gives the target plane and the column inside that plane's page, so the downstream bus sequencer can load the byte into the right cache register.

Each plane has two buffers: a cache register, which is modelled as a full/not-full flag, and a data register whose array program is modelled as a busy counter. When a plane's cache page is complete and its array is idle, the block moves the page to the data register and pulses a program-start strobe. The cache can then accept the next page while the array programs. The input stalls only when a plane's cache is full and its array is still busy. A flush request pads any partly filled pages with erased-state bytes (0xFF) and launches them, so that nothing is left behind at the end of a capture.

The control is a stream sequencer with two states. SEQ_RUN accepts input. SEQ_PAD emits padding until the current page set is complete, and then returns to SEQ_RUN. The transitions are SEQ_RUN to SEQ_PAD on a flush when a set is partly filled, and SEQ_PAD to SEQ_RUN once the last slot of the set has been written. Each plane has a small controller with two states. PL_IDLE moves to PL_PROG on a program strobe, and PL_PROG moves back to PL_IDLE when its counter runs out. A set tracker holds the shared page address. It advances that address once all four planes of a set have launched.

Top module: `nand_stripe_sched`

## Requirements
- R1: Write `k` of the stream (counting accepted bytes and pad bytes together, from reset) goes to plane `k mod 4` at column `(k div 4) mod PAGE_BYTES`. The plane index is encoded as follows: 0 is die0/plane0, 1 is die0/plane1, 2 is die1/plane0 and 3 is die1/plane1.
- R2: A byte accepted on a rising edge (`in_valid` and `in_ready` both high) appears on `wr_valid`/`wr_plane`/`wr_col`/`wr_data` during the following cycle. `wr_valid` is low in cycles with no write.
- R3: A plane's page is complete once column `PAGE_BYTES-1` has been written. The block raises that plane's bit of `prog_start` for one cycle when the page is complete, the plane's array is idle and the plane has not yet launched in the current set. A partly filled page is never launched on its own.
- R4: `plane_busy[p]` goes high in the cycle after `prog_start[p]` and stays high for exactly `PROG_CYCLES` cycles. `prog_start[p]` never rises while `plane_busy[p]` is high.
- R5: `in_ready` is low while the plane due to receive the next byte still holds a complete page that has not been launched. No byte is lost or duplicated across a stall.
- R6: Every program strobe of page set `s` (counting from 0) carries `prog_page == s`. `prog_page` changes only by incrementing by one, after all four planes of the set have launched.
- R7: A `flush` pulse given while a set is partly filled makes the block write 0xFF bytes in rotation until the set is complete. The block then launches all four pages. `in_ready` is low while padding.
- R8: A `flush` pulse given when the stream stands on a set boundary writes nothing and launches nothing.
- R9: `idle` is high only when the stream is on a set boundary, no cache page is pending, no array is busy and no padding is in progress.
- R10: Starting from idle, 8·`PAGE_BYTES` back-to-back bytes (two full sets) are accepted with `in_ready` never low. The first set programs while the second fills the caches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| flush | input | 1 | Pad and launch any partial page set |
| wr_valid | output | 1 | A byte is written to a cache register this cycle |
| wr_plane | output | 2 | Target plane (bit 1 = die, bit 0 = plane in die) |
| wr_col | output | COL_W | Column inside the target page |
| wr_data | output | 8 | Byte value (0xFF for padding) |
| prog_start | output | 4 | Per-plane program-start strobe |
| prog_page | output | PAGE_AW | Page address shared by the strobes of a set |
| plane_busy | output | 4 | Per-plane array program in progress |
| idle | output | 1 | Nothing buffered and nothing programming |

## Verification
The rotation and column order are tried with an unbroken burst, with a burst that has gaps every few bytes, and with a single isolated byte. These patterns separate correct ordering from dropped or repeated bytes, and confirm the one-cycle write latency. A burst of two full sets followed by one more byte separates working double buffering, where the first two sets pass with no stall, from a missing back-pressure path, where the extra byte is taken while its plane is still occupied. Flushes are given both on a partial set and on a set boundary. Together they show that padding is 0xFF and completes exactly one set, and that a flush on a boundary does nothing. A running model of strobes checks the page address of every launch and the length of every busy window.

// File: rtl/nand_stripe_pkg.sv
package nand_stripe_pkg;
    localparam int NUM_DIES       = 2;
    localparam int PLANES_PER_DIE = 2;
    localparam int NUM_PLANES     = NUM_DIES * PLANES_PER_DIE;
    localparam int PLANE_W        = $clog2(NUM_PLANES);
    localparam logic [7:0] PAD_BYTE = 8'hFF;

    typedef enum logic {
        SEQ_RUN,
        SEQ_PAD
    } seq_state_t;

    typedef enum logic {
        PL_IDLE,
        PL_PROG
    } pl_state_t;
endpackage

// File: rtl/nand_plane_ctl.sv
module nand_plane_ctl
    import nand_stripe_pkg::*;
#(
    parameter int PROG_CYCLES = 28000,
    localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fill_last,
    input  logic launch_ok,
    output logic cache_full,
    output logic busy,
    output logic prog_start
);
    pl_state_t        st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= PL_IDLE;
            cnt        <= '0;
            cache_full <= 1'b0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            if (fill_last)
                cache_full <= 1'b1;
            else if (prog_start)
                cache_full <= 1'b0;
        end
    end

    always_comb begin
        st_n       = st;
        cnt_n      = cnt;
        prog_start = 1'b0;
        unique case (st)
            PL_IDLE: begin
                if (cache_full && launch_ok) begin
                    prog_start = 1'b1;
                    st_n       = PL_PROG;
                    cnt_n      = CNT_W'(PROG_CYCLES - 1);
                end
            end
            PL_PROG: begin
                if (cnt == '0)
                    st_n = PL_IDLE;
                else
                    cnt_n = cnt - 1'b1;
            end
        endcase
    end

    assign busy = (st == PL_PROG);
endmodule

// File: rtl/nand_set_tracker.sv
module nand_set_tracker
    import nand_stripe_pkg::*;
#(
    parameter int PAGE_AW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PLANES-1:0] prog_start,
    output logic [NUM_PLANES-1:0] launch_ok,
    output logic [PAGE_AW-1:0]    prog_page
);
    logic [NUM_PLANES-1:0] done_mask;
    logic [NUM_PLANES-1:0] mask_n;

    assign mask_n    = done_mask | prog_start;
    assign launch_ok = ~done_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_mask <= '0;
            prog_page <= '0;
        end else if (&mask_n) begin
            done_mask <= '0;
            prog_page <= prog_page + 1'b1;
        end else begin
            done_mask <= mask_n;
        end
    end
endmodule

// File: rtl/nand_stripe_seq.sv
module nand_stripe_seq
    import nand_stripe_pkg::*;
#(
    parameter int PAGE_BYTES = 8640,
    localparam int COL_W = $clog2(PAGE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [7:0]            in_data,
    input  logic                  flush,
    input  logic [NUM_PLANES-1:0] cache_full,
    output logic                  in_ready,
    output logic                  wr_valid,
    output logic [PLANE_W-1:0]    wr_plane,
    output logic [COL_W-1:0]      wr_col,
    output logic [7:0]            wr_data,
    output logic [NUM_PLANES-1:0] fill_last,
    output logic                  at_boundary,
    output logic                  padding
);
    localparam logic [COL_W-1:0]   LAST_COL = COL_W'(PAGE_BYTES - 1);
    localparam logic [PLANE_W-1:0] LAST_PL  = PLANE_W'(NUM_PLANES - 1);

    seq_state_t         st, st_n;
    logic [PLANE_W-1:0] rr;
    logic [COL_W-1:0]   col;
    logic               slot_free, acc, pad_en, wr_en, last_slot, bound_after;

    assign slot_free   = !cache_full[rr];
    assign in_ready    = (st == SEQ_RUN) && slot_free;
    assign acc         = in_ready && in_valid;
    assign pad_en      = (st == SEQ_PAD) && slot_free;
    assign wr_en       = acc || pad_en;
    assign last_slot   = (rr == LAST_PL) && (col == LAST_COL);
    assign at_boundary = (rr == '0) && (col == '0);
    assign bound_after = wr_en ? last_slot : at_boundary;
    assign padding     = (st == SEQ_PAD);

    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_fill
        assign fill_last[p] = wr_en && (rr == PLANE_W'(p)) && (col == LAST_COL);
    end

    always_comb begin
        st_n = st;
        unique case (st)
            SEQ_RUN: if (flush && !bound_after) st_n = SEQ_PAD;
            SEQ_PAD: if (pad_en && last_slot)   st_n = SEQ_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= SEQ_RUN;
        end else begin
            st <= st_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr       <= '0;
            col      <= '0;
            wr_valid <= 1'b0;
            wr_plane <= '0;
            wr_col   <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= wr_en;
            if (wr_en) begin
                wr_plane <= rr;
                wr_col   <= col;
                wr_data  <= acc ? in_data : PAD_BYTE;
                rr       <= rr + 1'b1;
                if (rr == LAST_PL)
                    col <= (col == LAST_COL) ? '0 : col + 1'b1;
            end
        end
    end
endmodule

// File: rtl/nand_stripe_sched.sv
module nand_stripe_sched
    import nand_stripe_pkg::*;
#(
    parameter int PAGE_BYTES  = 8640,
    parameter int PROG_CYCLES = 28000,
    parameter int PAGE_AW     = 16,
    localparam int COL_W = $clog2(PAGE_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    output logic               in_ready,
    input  logic               flush,
    output logic               wr_valid,
    output logic [1:0]         wr_plane,
    output logic [COL_W-1:0]   wr_col,
    output logic [7:0]         wr_data,
    output logic [3:0]         prog_start,
    output logic [PAGE_AW-1:0] prog_page,
    output logic [3:0]         plane_busy,
    output logic               idle
);
    logic [NUM_PLANES-1:0] cache_full, fill_last, launch_ok;
    logic                  at_boundary, padding;

    nand_stripe_seq #(.PAGE_BYTES(PAGE_BYTES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .flush      (flush),
        .cache_full (cache_full),
        .in_ready   (in_ready),
        .wr_valid   (wr_valid),
        .wr_plane   (wr_plane),
        .wr_col     (wr_col),
        .wr_data    (wr_data),
        .fill_last  (fill_last),
        .at_boundary(at_boundary),
        .padding    (padding)
    );

    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
        nand_plane_ctl #(.PROG_CYCLES(PROG_CYCLES)) u_pl (
            .clk       (clk),
            .rst_n     (rst_n),
            .fill_last (fill_last[p]),
            .launch_ok (launch_ok[p]),
            .cache_full(cache_full[p]),
            .busy      (plane_busy[p]),
            .prog_start(prog_start[p])
        );
    end

    nand_set_tracker #(.PAGE_AW(PAGE_AW)) u_set (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_start(prog_start),
        .launch_ok (launch_ok),
        .prog_page (prog_page)
    );

    assign idle = at_boundary && !padding && (cache_full == '0) && (plane_busy == '0);
endmodule

// File: rtl/nand_stripe_chk.sv
module nand_stripe_chk #(
    parameter int PAGE_AW = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_valid,
    input logic [1:0]         wr_plane,
    input logic [3:0]         prog_start,
    input logic [PAGE_AW-1:0] prog_page,
    input logic [3:0]         plane_busy,
    input logic               idle
);
    for (genvar p = 0; p < 4; p++) begin : g_pl
        p_busy_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
            prog_start[p] |=> plane_busy[p]);
        p_no_strobe_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
            prog_start[p] |-> !plane_busy[p]);
    end

    p_page_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prog_page) |-> prog_page == $past(prog_page) + 1'b1);

    p_rotation_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(wr_valid)) |-> wr_plane == $past(wr_plane) + 2'd1);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (plane_busy == 4'd0) && (prog_start == 4'd0));
endmodule

bind nand_stripe_sched nand_stripe_chk #(.PAGE_AW(PAGE_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_plane  (wr_plane),
    .prog_start(prog_start),
    .prog_page (prog_page),
    .plane_busy(plane_busy),
    .idle      (idle)
);

// File: tb/sim_nand_stripe_sched.sv
module sim_nand_stripe_sched;
    localparam int PAGE  = 8;
    localparam int PROG  = 40;
    localparam int PAW   = 8;
    localparam int COLW  = $clog2(PAGE);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [7:0]      in_data = 8'd0;
    logic            flush = 1'b0;
    logic            in_ready, wr_valid, idle;
    logic [1:0]      wr_plane;
    logic [COLW-1:0] wr_col;
    logic [7:0]      wr_data;
    logic [3:0]      prog_start, plane_busy;
    logic [PAW-1:0]  prog_page;

    int errors = 0;
    int checks = 0;
    int wcount = 0;
    int strobes = 0;
    int busy_len [4];
    logic [7:0] seed = 8'h10;
    logic [7:0] q [$];
    bit finished = 0;

    always #2 clk = ~clk;

    nand_stripe_sched #(.PAGE_BYTES(PAGE), .PROG_CYCLES(PROG), .PAGE_AW(PAW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .flush(flush), .wr_valid(wr_valid),
        .wr_plane(wr_plane), .wr_col(wr_col), .wr_data(wr_data),
        .prog_start(prog_start), .prog_page(prog_page),
        .plane_busy(plane_busy), .idle(idle)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Stream, page-address and busy-window model
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 4; p++) busy_len[p] = 0;
        end else begin
            if (wr_valid) begin
                chk(wr_plane == 2'(wcount % 4), "R1", "plane", wr_plane, wcount % 4);
                chk(wr_col == COLW'((wcount / 4) % PAGE), "R1", "column", wr_col, (wcount / 4) % PAGE);
                if (q.size() > 0) begin
                    logic [7:0] e;
                    e = q.pop_front();
                    chk(wr_data == e, "R2", "data", wr_data, e);
                end else begin
                    chk(wr_data == 8'hFF, "R7", "pad byte", wr_data, 255);
                end
                wcount++;
            end
            for (int p = 0; p < 4; p++) begin
                if (prog_start[p]) begin
                    chk(prog_page == PAW'(strobes / 4), "R6", "strobe page", prog_page, strobes / 4);
                    strobes++;
                end
                if (plane_busy[p]) begin
                    busy_len[p]++;
                end else if (busy_len[p] != 0) begin
                    chk(busy_len[p] == PROG, "R4", "busy length", busy_len[p], PROG);
                    busy_len[p] = 0;
                end
            end
        end
    end

    task automatic send(input int n, input int gap, output int stalls);
        stalls = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (gap > 0 && i % gap == gap - 1) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = seed;
            while (!in_ready) begin
                stalls++;
                @(negedge clk);
            end
            q.push_back(seed);
            seed = seed + 8'd7;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (!idle && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(idle == 1'b1, req, "reached idle", idle, 1);
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic t_reset();
        chk(idle == 1'b1, "R9", "idle after reset", idle, 1);
        chk(in_ready == 1'b1, "R5", "ready after reset", in_ready, 1);
        chk(plane_busy == 4'd0, "R4", "busy after reset", plane_busy, 0);
        chk(wr_valid == 1'b0, "R2", "no write after reset", wr_valid, 0);
        chk(prog_page == '0, "R6", "page after reset", prog_page, 0);
    endtask

    task automatic t_double_buffer();
        int st;
        send(8 * PAGE, 0, st);
        chk(st == 0, "R10", "stalls over two sets", st, 0);
        send(1, 0, st);
        chk(st > 0, "R5", "stall on occupied plane", st, 1);
        repeat (3 * PROG) @(negedge clk);
        chk(strobes == 8, "R3", "partial set not launched", strobes, 8);
        chk(idle == 1'b0, "R9", "idle with partial page", idle, 0);
        pulse_flush();
        chk(in_ready == 1'b0, "R7", "ready while padding", in_ready, 0);
        wait_idle("R7");
        chk(wcount == 12 * PAGE, "R7", "writes after pad", wcount, 12 * PAGE);
        chk(strobes == 12, "R7", "pages launched after pad", strobes, 12);
    endtask

    task automatic t_single_and_gaps();
        int st;
        logic [7:0] b;
        @(negedge clk);
        b = seed;
        in_valid = 1'b1;
        in_data  = b;
        chk(in_ready == 1'b1, "R5", "ready when idle", in_ready, 1);
        q.push_back(b);
        seed = seed + 8'd7;
        @(negedge clk);
        in_valid = 1'b0;
        chk(wr_valid == 1'b1 && wr_data == b, "R2", "write one cycle later", wr_data, b);
        chk(wr_plane == 2'd0, "R1", "first plane of set", wr_plane, 0);
        @(negedge clk);
        chk(wr_valid == 1'b0, "R2", "no write without input", wr_valid, 0);
        send(20, 3, st);
        pulse_flush();
        wait_idle("R7");
        chk(wcount == 16 * PAGE, "R7", "writes after second pad", wcount, 16 * PAGE);
        chk(strobes == 16, "R3", "pages launched", strobes, 16);
    endtask

    task automatic t_flush_boundary();
        int w0 = wcount;
        int s0 = strobes;
        pulse_flush();
        repeat (10) @(negedge clk);
        chk(wcount == w0, "R8", "no pad at boundary", wcount, w0);
        chk(strobes == s0, "R8", "no launch at boundary", strobes, s0);
        chk(in_ready == 1'b1 && idle == 1'b1, "R8", "ready and idle stay", in_ready, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_double_buffer();
        t_single_and_gaps();
        t_flush_boundary();
        chk(q.size() == 0, "R1", "stream drained", q.size(), 0);
        chk(prog_page == PAW'(strobes / 4), "R6", "final page", prog_page, strobes / 4);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule